// File: doc/BRIEF.md
# Programmable Edge Delay Timer

This block holds back chosen transitions of a single-bit input for a programmable number of master timing ticks, then lets its output take the new level. A free-running tick enable stands in for the master oscillator period. A 4-bit configuration code selects the divide ratio and supplies a polarity bit. The whole delay equals the ratio times the tick period.

A compile-time mode sets what the polarity bit means. In edge-select mode it picks which direction of input edge is held back, and the other direction reaches the output on the next clock. In invert mode every edge is held back and the polarity bit inverts the output. Timing runs only while a held-back transition is pending. An input that returns to the output's level before the delay ends cancels it. The ratio is captured when a delay starts, so a code change during a delay does not affect that delay.

All pins are plain level signals with no handshake, because the block carries one level and no data stream. The input is sampled on every rising clock edge.

Top module: `edge_delay_timer`

## Requirements
- R1: `cfg_code[SEL_W]` (bit 3 by default) is the polarity bit. `cfg_code[SEL_W-1:0]` is a selector `s`, and the divide ratio is 2^(EXP_STEP*s). With the defaults (EXP_STEP = 3) this gives 1, 8, 64, 512, 4096, 2^15, 2^18 and 2^21 for s = 0 to 7.
- R2: A delayed transition is captured on the clock edge where the input first differs from the output level. A tick on that capture edge is not counted. The output takes the new level on the clock edge that carries the ratio-th tick after the capture edge, and never earlier.
- R3: Only clock edges with `tick` high advance the delay. With `tick` low, a pending delay holds indefinitely and the output does not change.
- R4: In edge-select mode with polarity 0, rising edges are delayed and falling edges reach the output on the first clock edge after the input changes.
- R5: In edge-select mode with polarity 1, falling edges are delayed and rising edges reach the output on the first clock edge after the input changes.
- R6: In invert mode both edge directions are delayed. After a delay completes, the output equals the input level XOR the polarity bit that was present when that delay began.
- R7: If the input returns to the current output level while a delay is pending, the delay is dropped and the output does not change.
- R8: A pending delay keeps the ratio captured at its start, even if `cfg_code` changes while it runs.
- R9: Reset is synchronous and active low. While reset is asserted, the output follows the sampled input (XOR the polarity bit in invert mode), and any pending delay is discarded.
- R10: The tick count is zero whenever no delay is pending. A delay that starts after a cancelled or completed one therefore takes the full ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Master tick enable; one high cycle is one timing unit |
| cfg_code | input | SEL_W+1 | Polarity bit (MSB) and ratio selector (lower bits) |
| sig_in | input | 1 | Level whose transitions are delayed |
| dout | output | 1 | Delayed (and, in invert mode, optionally inverted) level |

## Verification
The bench sweeps every selector value against both polarities, both edge directions and both modes on a reduced-exponent instance. It counts the ticks between the capture edge and the output change, so an off-by-one that counts the capture tick, or a ratio table that skips a step, shows up as a wrong tick count. A stretch with the tick enable held low catches a counter that advances on the clock alone. A glitch that returns before the delay ends catches a design that lets the output change anyway or keeps a stale count into the next delay. A code change in the middle of a delay catches a design that reads the ratio live. Reset applied during a pending delay must give the current input level at once and no late transition afterwards. A default-parameter instance confirms the power-of-eight ratios up to 4096.

// File: rtl/edt_pkg.sv
package edt_pkg;
  // Meaning of the polarity bit, fixed at elaboration.
  typedef enum logic {
    EDT_EDGE_SELECT = 1'b0,   // polarity picks which edge direction is held back
    EDT_INVERT      = 1'b1    // every edge held back, polarity inverts the output
  } edt_mode_e;
endpackage

// File: rtl/edt_ratio_decode.sv
// Maps the ratio selector to a terminal count (ratio - 1).
module edt_ratio_decode #(
  parameter int SEL_W    = 3,
  parameter int EXP_STEP = 3,
  parameter int CNT_W    = 21
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] lim
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] lim_tab [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    localparam int SHIFT = EXP_STEP * i;
    // Build the value one bit wider so that the largest ratio
    // (2^CNT_W) still gives a correct terminal count.
    localparam logic [CNT_W:0] TERM =
      ((CNT_W+1)'(1) << SHIFT) - (CNT_W+1)'(1);
    assign lim_tab[i] = TERM[CNT_W-1:0];
  end

  assign lim = lim_tab[sel];
endmodule

// File: rtl/edt_edge_classify.sv
// Works out whether the input differs from the held level and whether
// that difference has to be timed.
module edt_edge_classify
  import edt_pkg::*;
#(
  parameter edt_mode_e MODE = EDT_EDGE_SELECT
) (
  input  logic sig_in,
  input  logic held,
  input  logic pol,
  output logic differs,
  output logic delayable
);
  assign differs = sig_in ^ held;

  if (MODE == EDT_INVERT) begin : g_inv
    logic unused_pol;
    assign unused_pol = pol;
    assign delayable  = differs;
  end else begin : g_sel
    // pol 0: new level 1 (rising) is timed; pol 1: new level 0 (falling) is timed
    assign delayable = differs & (sig_in ^ pol);
  end
endmodule

// File: rtl/edt_tick_counter.sv
// Counts master ticks for one pending delay, using the ratio captured at start.
module edt_tick_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] lim_cur,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (start) lim_q <= lim_in;
      if (start || clear) cnt_q <= '0;
      else if (run && tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count   = cnt_q;
  assign lim_cur = lim_q;
  assign expire  = run & tick & (cnt_q == lim_q);
endmodule

// File: rtl/edge_delay_timer.sv
module edge_delay_timer
  import edt_pkg::*;
#(
  parameter edt_mode_e MODE     = EDT_EDGE_SELECT,
  parameter int        SEL_W    = 3,
  parameter int        EXP_STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W:0]   cfg_code,
  input  logic             sig_in,
  output logic             dout
);
  localparam int SPAN  = EXP_STEP * ((1 << SEL_W) - 1);
  localparam int CNT_W = (SPAN > 0) ? SPAN : 1;

  logic             pol_cur;
  logic [SEL_W-1:0] sel_cur;
  logic             held_q;
  logic             busy_q;
  logic             differs;
  logic             delayable;
  logic             start;
  logic             cancel;
  logic             finish;
  logic             expire;
  logic [CNT_W-1:0] lim_sel;
  logic [CNT_W-1:0] lim_cur;
  logic [CNT_W-1:0] cnt;

  assign pol_cur = cfg_code[SEL_W];
  assign sel_cur = cfg_code[SEL_W-1:0];

  edt_ratio_decode #(
    .SEL_W   (SEL_W),
    .EXP_STEP(EXP_STEP),
    .CNT_W   (CNT_W)
  ) u_ratio (
    .sel(sel_cur),
    .lim(lim_sel)
  );

  edt_edge_classify #(
    .MODE(MODE)
  ) u_classify (
    .sig_in   (sig_in),
    .held     (held_q),
    .pol      (pol_cur),
    .differs  (differs),
    .delayable(delayable)
  );

  assign start  = ~busy_q & delayable;
  assign cancel = busy_q & ~differs;
  assign finish = busy_q & differs & expire;

  edt_tick_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .clear  (cancel | finish),
    .run    (busy_q),
    .tick   (tick),
    .lim_in (lim_sel),
    .count  (cnt),
    .lim_cur(lim_cur),
    .expire (expire)
  );

  // Held level and pending flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= sig_in;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cancel) begin
        busy_q <= 1'b0;
      end else if (finish) begin
        held_q <= sig_in;
        busy_q <= 1'b0;
      end
    end else if (differs) begin
      if (delayable) busy_q <= 1'b1;
      else           held_q <= sig_in;
    end
  end

  if (MODE == EDT_INVERT) begin : g_out_inv
    logic pol_pend_q;
    logic pol_out_q;
    // Polarity is captured when a delay starts and applied when it finishes,
    // so the output moves only at the end of a delay.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pol_pend_q <= pol_cur;
        pol_out_q  <= pol_cur;
      end else begin
        if (start)  pol_pend_q <= pol_cur;
        if (finish) pol_out_q  <= pol_pend_q;
      end
    end
    assign dout = held_q ^ pol_out_q;
  end else begin : g_out_sel
    assign dout = held_q;
  end
endmodule

// File: rtl/edt_checker.sv
module edt_checker
  import edt_pkg::*;
#(
  parameter edt_mode_e MODE  = EDT_EDGE_SELECT,
  parameter int        CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sig_in,
  input logic             pol_cur,
  input logic             held_q,
  input logic             busy_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim_cur,
  input logic             dout
);
  AST_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(tick && cnt == lim_cur)) |=> $stable(dout)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt <= lim_cur)); // R2

  AST_TICK_GATES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> (!busy_q || $stable(cnt))); // R3

  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sig_in == held_q) |=> (!busy_q && $stable(dout))); // R7

  AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(lim_cur))); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt == '0)); // R10

  if (MODE == EDT_INVERT) begin : g_inv
    logic unused_pol;
    assign unused_pol = pol_cur;
    AST_ALL_EDGES_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && sig_in != held_q) |=> busy_q); // R6
  end else begin : g_sel
    AST_PASS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && sig_in != held_q && sig_in == pol_cur) |=>
        (!busy_q && held_q == $past(sig_in))); // R4 R5
    AST_HOLD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && sig_in != held_q && sig_in != pol_cur) |=> busy_q); // R4 R5
  end
endmodule

bind edge_delay_timer edt_checker #(
  .MODE (MODE),
  .CNT_W(CNT_W)
) u_edt_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .sig_in (sig_in),
  .pol_cur(pol_cur),
  .held_q (held_q),
  .busy_q (busy_q),
  .cnt    (cnt),
  .lim_cur(lim_cur),
  .dout   (dout)
);

// File: tb/edge_delay_timer_bench.sv
module edge_delay_timer_bench;
  import edt_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [3:0] code [3];
  logic       sin  [3];
  logic       dout [3];

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  // idx 0: edge-select, ratios 2^s
  edge_delay_timer #(.MODE(EDT_EDGE_SELECT), .SEL_W(3), .EXP_STEP(1)) u_edge_delay_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_code(code[0]), .sig_in(sin[0]), .dout(dout[0]));
  // idx 1: invert mode, ratios 2^s
  edge_delay_timer #(.MODE(EDT_INVERT), .SEL_W(3), .EXP_STEP(1)) u_edge_delay_timer_inv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_code(code[1]), .sig_in(sin[1]), .dout(dout[1]));
  // idx 2: default parameters, ratios 8^s
  edge_delay_timer u_edge_delay_timer_def (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_code(code[2]), .sig_in(sin[2]), .dout(dout[2]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Waits for dout[idx] to change; counts clock edges and counted ticks.
  task automatic wait_change(input int idx, input bit slow, input bit skip_first,
                             output int e, output int tk);
    logic prev;
    prev = dout[idx];
    e  = 0;
    tk = 0;
    while (e < 6000) begin
      @(posedge clk);
      e++;
      if (tick && !(skip_first && e == 1)) tk++;
      @(negedge clk);
      if (dout[idx] !== prev) break;
      tick = slow ? ((e % 3) == 1) : 1'b1;
    end
  endtask

  task automatic run_edge(input int idx, input logic v, input bit slow, input int exp_ticks,
                          input bit pass, input string req, input logic exp_out);
    int e, tk;
    sin[idx] = v;
    tick = 1'b1;
    wait_change(idx, slow, 1'b1, e, tk);
    if (pass) check(e == 1, req, "pass-through latency in edges", e, 1);
    else      check(tk == exp_ticks, {"R2 ", req}, "ticks to output change", tk, exp_ticks);
    check(dout[idx] === exp_out, req, "output level", int'(dout[idx]), int'(exp_out));
    tick = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int e, tk;
    bit bad;
    logic v;
    rst_n = 1'b0;
    tick  = 1'b1;
    code[0] = 4'b0000; sin[0] = 1'b1;
    code[1] = 4'b1000; sin[1] = 1'b1;
    code[2] = 4'b0000; sin[2] = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(dout[0] === 1'b1, "R9", "edge-mode reset level", int'(dout[0]), 1);
    check(dout[1] === 1'b0, "R9", "invert-mode reset level", int'(dout[1]), 0);
    check(dout[2] === 1'b0, "R9", "default reset level", int'(dout[2]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // bring idx0 back to 0 (pol 0: falling passes)
    run_edge(0, 1'b0, 1'b0, 0, 1'b1, "R4", 1'b0);

    // Edge-select sweep: R4 (pol 0) and R5 (pol 1)
    for (int pol = 0; pol < 2; pol++) begin
      for (int s = 0; s < 8; s++) begin
        for (int slow = 0; slow < 2; slow++) begin
          code[0] = {pol[0], s[2:0]};
          @(negedge clk);
          run_edge(0, 1'b1, slow[0], 1 << s, pol == 1, pol == 0 ? "R4" : "R5", 1'b1);
          run_edge(0, 1'b0, slow[0], 1 << s, pol == 0, pol == 0 ? "R4" : "R5", 1'b0);
        end
      end
    end

    // Invert-mode sweep: R6
    for (int pol = 0; pol < 2; pol++) begin
      code[1] = {pol[0], 3'd0};
      v = ~sin[1];
      sin[1] = v;
      repeat (6) @(negedge clk);
      check(dout[1] === (v ^ pol[0]), "R6", "settled inverted level", int'(dout[1]), int'(v ^ pol[0]));
      for (int s = 0; s < 8; s++) begin
        for (int slow = 0; slow < 2; slow++) begin
          code[1] = {pol[0], s[2:0]};
          @(negedge clk);
          v = ~sin[1];
          run_edge(1, v, slow[0], 1 << s, 1'b0, "R6", v ^ pol[0]);
          v = ~sin[1];
          run_edge(1, v, slow[0], 1 << s, 1'b0, "R6", v ^ pol[0]);
        end
      end
    end

    // Default-parameter ratios: R1
    for (int s = 0; s < 5; s++) begin
      code[2] = {1'b0, s[2:0]};
      @(negedge clk);
      run_edge(2, 1'b1, 1'b0, 1 << (3 * s), 1'b0, "R1", 1'b1);
      run_edge(2, 1'b0, 1'b0, 0, 1'b1, "R1", 1'b0);
    end

    // R3: tick held low stalls a pending delay
    code[0] = 4'b0010;  // pol 0, ratio 4
    @(negedge clk);
    sin[0] = 1'b1;
    tick = 1'b1;
    @(posedge clk);     // capture edge
    @(negedge clk);
    tick = 1'b0;
    bad = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (dout[0] !== 1'b0) bad = 1'b1;
    end
    check(!bad, "R3", "output moved with tick low", int'(bad), 0);
    tick = 1'b1;
    wait_change(0, 1'b0, 1'b0, e, tk);
    check(tk == 4, "R3", "ticks after stall", tk, 4);
    run_edge(0, 1'b0, 1'b0, 0, 1'b1, "R4", 1'b0);

    // R7: glitch shorter than the delay is dropped
    code[0] = 4'b0011;  // ratio 8
    @(negedge clk);
    sin[0] = 1'b1;
    repeat (5) @(negedge clk);
    sin[0] = 1'b0;
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (dout[0] !== 1'b0) bad = 1'b1;
    end
    check(!bad, "R7", "output moved after cancelled edge", int'(bad), 0);
    // R10: next delay takes the full ratio
    run_edge(0, 1'b1, 1'b0, 8, 1'b0, "R10", 1'b1);
    run_edge(0, 1'b0, 1'b0, 0, 1'b1, "R10", 1'b0);

    // R8: code change mid-delay does not alter the ratio
    code[0] = 4'b0010;  // ratio 4
    @(negedge clk);
    sin[0] = 1'b1;
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    code[0] = 4'b0101;  // ratio 32
    wait_change(0, 1'b0, 1'b0, e, tk);
    check(tk == 4, "R8", "ticks with code changed mid-delay", tk, 4);
    code[0] = 4'b0000;
    run_edge(0, 1'b0, 1'b0, 0, 1'b1, "R8", 1'b0);

    // R9: reset during a pending delay
    code[0] = 4'b0011;
    @(negedge clk);
    sin[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dout[0] === 1'b1, "R9", "reset takes input level", int'(dout[0]), 1);
    check(dout[1] === (sin[1] ^ code[1][3]), "R9", "invert reset level",
          int'(dout[1]), int'(sin[1] ^ code[1][3]));
    rst_n = 1'b1;
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (dout[0] !== 1'b1) bad = 1'b1;
    end
    check(!bad, "R9", "no late transition after reset", int'(bad), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule